// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 32-bit unsigned operands and a single carry-in. It produces a 32-bit sum and a carry-out. It is purely combinational: no clock, no state, no latency.

The word is split into eight 4-bit slices. Each slice forms per-bit propagate and generate terms. It computes its own sum bits from a local carry-in, and it reports one group propagate and one group generate signal. Two lookahead units, each covering four consecutive slices, turn these group signals into the carry-in of every slice. The lower unit receives the external carry-in. The upper unit receives the lower unit's carry-out, and the upper unit's carry-out is the carry-out of the whole adder.

Slice width, slices per lookahead unit and word width are parameters. The default build has 32 bits, two units and four slices per unit.

Top module: `lookahead_adder`

## Requirements
- R1: `sumOut` equals `opA + opB + carryIn` modulo 2^32 for every combination of inputs.
- R2: `carryOut` equals bit 32 of the 33-bit sum `opA + opB + carryIn`.
- R3: Each 4-bit slice produces sum bits equal to the arithmetic sum of its operand bits and its local carry-in, so a lone `carryIn` of 1 with zero operands gives a sum of 1.
- R4: A slice reports group propagate exactly when every one of its bit positions has exactly one operand bit set. A carry then passes straight through it: with `opA ^ opB` all ones and `carryIn` = 1, the sum is 0 and the carry-out is 1.
- R5: A slice reports group generate exactly when its two 4-bit operands add to 16 or more. It then carries out whatever its carry-in is: 0x88888888 + 0x88888888 gives 0x11111110 with a carry-out of 1.
- R6: Each lookahead unit gives every slice a carry-in equal to `G(k-1) | P(k-1)·c(k-1)` over the slices below it. A generate in a low slice therefore reaches a distant slice through a chain of propagating slices.
- R7: The carry into bit 16 equals the carry out of the 17-bit sum of the low halves plus `carryIn`. The upper unit is fed only from the lower unit's carry-out.
- R8: The outputs follow any input change in the same time step, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First addend |
| opB | input | 32 | Second addend |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | 32 | Low 32 bits of the sum |
| carryOut | output | 1 | Bit 32 of the sum |

## Verification
The bench targets carries that must travel far:
- **Full-width ripple.** All-ones plus one and complementary patterns with a carry-in make the carry cross every slice. A broken group-propagate term leaves stray ones in the sum or loses the carry-out.
- **Every slice generating.** Operands of 0x88888888 make every slice generate at once. A wrong group-generate term drops bits 4, 8, 12 and upward.
- **Half boundary.** 0x0000FFFF plus one, with a carry-in or with an operand, must set bit 16. A wrong hand-off between the two lookahead units leaves the upper half unchanged.
- **Distant generate.** A generate in slice 0 must reach slice 7 through six propagating slices. A mis-expanded lookahead term breaks this case.

Random vectors then cover ordinary mixes of all three cases.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // Widest span any single lookahead expansion is asked to cover.
  localparam int MAX_SPAN = 32;

  typedef struct packed {
    logic prop;  // carry passes through the group
    logic gen;   // group creates a carry by itself
  } grpSig_t;

  // Carry into position `upto`, written as a flat sum of products:
  // OR over j<upto of g[j] & p[j+1..upto-1], plus p[0..upto-1] & cIn.
  function automatic logic lookCarry(input logic [MAX_SPAN-1:0] p,
                                     input logic [MAX_SPAN-1:0] g,
                                     input logic cIn,
                                     input int upto);
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < MAX_SPAN; j++) begin
      if (j < upto) begin
        term = g[j];
        for (int k = 0; k < MAX_SPAN; k++)
          if (k > j && k < upto) term = term & p[k];
        acc = acc | term;
      end
    end
    term = cIn;
    for (int k = 0; k < MAX_SPAN; k++)
      if (k < upto) term = term & p[k];
    return acc | term;
  endfunction

endpackage

// File: rtl/cla_slice.sv
module cla_slice
  import cla_pkg::*;
#(
  parameter int SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] opA,
  input  logic [SLICE_W-1:0] opB,
  input  logic               carryIn,
  output logic [SLICE_W-1:0] sumOut,
  output grpSig_t            grp
);

  logic [SLICE_W-1:0] bitP;
  logic [SLICE_W-1:0] bitG;
  logic [SLICE_W-1:0] bitCarry;

  assign bitP = opA ^ opB;
  assign bitG = opA & opB;

  always_comb begin
    for (int i = 0; i < SLICE_W; i++)
      bitCarry[i] = lookCarry(MAX_SPAN'(bitP), MAX_SPAN'(bitG), carryIn, i);
  end

  assign sumOut   = bitP ^ bitCarry;
  assign grp.prop = &bitP;
  assign grp.gen  = lookCarry(MAX_SPAN'(bitP), MAX_SPAN'(bitG), 1'b0, SLICE_W);

  // Arithmetic views of the slice, used only by the checks below.
  logic [SLICE_W:0] arithSum;
  logic [SLICE_W:0] arithPair;
  assign arithSum  = {1'b0, opA} + {1'b0, opB} + {{SLICE_W{1'b0}}, carryIn};
  assign arithPair = {1'b0, opA} + {1'b0, opB};

  always_comb begin
    // R3: slice sum and its implied carry match the arithmetic sum
    a_r3_slice_sum: assert ({grp.gen | (grp.prop & carryIn), sumOut} == arithSum)
      else $error("slice sum mismatch");
    // R4: propagate exactly when the operands add to all ones
    a_r4_group_prop: assert (grp.prop == (arithPair == {1'b0, {SLICE_W{1'b1}}}))
      else $error("group propagate wrong");
    // R5: generate exactly when the operands overflow the slice
    a_r5_group_gen: assert (grp.gen == arithPair[SLICE_W])
      else $error("group generate wrong");
  end

endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead
  import cla_pkg::*;
#(
  parameter int GROUPS = 4
) (
  input  grpSig_t [GROUPS-1:0] grpIn,
  input  logic                 carryIn,
  output logic    [GROUPS-1:0] grpCarry,  // carry into each group
  output logic                 carryOut
);

  logic [GROUPS-1:0] grpP;
  logic [GROUPS-1:0] grpG;

  always_comb begin
    for (int k = 0; k < GROUPS; k++) begin
      grpP[k] = grpIn[k].prop;
      grpG[k] = grpIn[k].gen;
    end
    for (int k = 0; k < GROUPS; k++)
      grpCarry[k] = lookCarry(MAX_SPAN'(grpP), MAX_SPAN'(grpG), carryIn, k);
    carryOut = lookCarry(MAX_SPAN'(grpP), MAX_SPAN'(grpG), carryIn, GROUPS);
  end

  always_comb begin
    // R6: flat carries agree with the one-step recurrence
    a_r6_first_carry: assert (grpCarry[0] == carryIn)
      else $error("first group carry wrong");
    for (int k = 1; k < GROUPS; k++)
      a_r6_recurrence: assert (grpCarry[k] ==
                              (grpIn[k-1].gen | (grpIn[k-1].prop & grpCarry[k-1])))
        else $error("group carry %0d breaks recurrence", k);
    a_r6_unit_out: assert (carryOut ==
                          (grpIn[GROUPS-1].gen | (grpIn[GROUPS-1].prop & grpCarry[GROUPS-1])))
      else $error("unit carry-out wrong");
  end

endmodule

// File: rtl/lookahead_adder.sv
module lookahead_adder
  import cla_pkg::*;
#(
  parameter int DATA_W          = 32,
  parameter int SLICE_W         = 4,
  parameter int GROUPS_PER_UNIT = 4
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  output logic [DATA_W-1:0] sumOut,
  output logic              carryOut
);

  localparam int NUM_SLICES = DATA_W / SLICE_W;
  localparam int NUM_UNITS  = NUM_SLICES / GROUPS_PER_UNIT;
  localparam int UNIT_W     = SLICE_W * GROUPS_PER_UNIT;

  grpSig_t [NUM_SLICES-1:0] sliceGrp;
  logic    [NUM_SLICES-1:0] sliceCarry;
  logic    [NUM_UNITS:0]    unitCarry;

  assign unitCarry[0] = carryIn;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    cla_slice #(.SLICE_W(SLICE_W)) u_slice (
      .opA     (opA[s*SLICE_W +: SLICE_W]),
      .opB     (opB[s*SLICE_W +: SLICE_W]),
      .carryIn (sliceCarry[s]),
      .sumOut  (sumOut[s*SLICE_W +: SLICE_W]),
      .grp     (sliceGrp[s])
    );
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    cla_lookahead #(.GROUPS(GROUPS_PER_UNIT)) u_look (
      .grpIn    (sliceGrp[u*GROUPS_PER_UNIT +: GROUPS_PER_UNIT]),
      .carryIn  (unitCarry[u]),
      .grpCarry (sliceCarry[u*GROUPS_PER_UNIT +: GROUPS_PER_UNIT]),
      .carryOut (unitCarry[u+1])
    );
  end

  assign carryOut = unitCarry[NUM_UNITS];

  // Arithmetic views, used only by the checks below.
  logic [DATA_W:0] wideSum;
  logic [UNIT_W:0] lowSum;
  assign wideSum = {1'b0, opA} + {1'b0, opB} + {{DATA_W{1'b0}}, carryIn};
  assign lowSum  = {1'b0, opA[UNIT_W-1:0]} + {1'b0, opB[UNIT_W-1:0]}
                 + {{UNIT_W{1'b0}}, carryIn};

  always_comb begin
    // R1: low word of the result
    a_r1_sum: assert (sumOut == wideSum[DATA_W-1:0])
      else $error("sum mismatch");
    // R2: carry-out is the extra top bit
    a_r2_carry_out: assert (carryOut == wideSum[DATA_W])
      else $error("carry-out mismatch");
    // R7: carry into the upper unit's first slice
    a_r7_unit_boundary: assert (sliceCarry[GROUPS_PER_UNIT] == lowSum[UNIT_W])
      else $error("carry across unit boundary wrong");
  end

endmodule

// File: tb/lookahead_adder_bench.sv
module lookahead_adder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int NUM_RAND   = 3000;
  localparam int NUM_VEC    = 8;

  // {opA, opB, carryIn}
  localparam logic [64:0] VEC_TABLE [NUM_VEC] = '{
    {32'h0000_0001, 32'h0000_0002, 1'b0},
    {32'h1234_5678, 32'h8765_4321, 1'b0},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1},
    {32'h8000_0000, 32'h8000_0000, 1'b0},
    {32'h0F0F_0F0F, 32'hF0F0_F0F0, 1'b0},
    {32'hDEAD_BEEF, 32'h2152_4111, 1'b1},
    {32'h7FFF_FFFF, 32'h0000_0001, 1'b0},
    {32'h0000_0000, 32'hFFFF_FFFF, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        carryIn = 1'b0;
  logic [31:0] sumOut;
  logic        carryOut;
  int          checkCount = 0;
  int          failCount = 0;
  int          cycleCount = 0;
  bit          done = 1'b0;

  lookahead_adder u_lookahead_adder (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .sumOut   (sumOut),
    .carryOut (carryOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycleCount <= cycleCount + 1;
    if (!done && cycleCount > WATCHDOG) begin
      failCount = failCount + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under %0d", cycleCount, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  task automatic checkResult(input string req, input logic [32:0] actual,
                             input logic [32:0] expected);
    checkCount++;
    if (actual !== expected) begin
      failCount++;
      $display("FAIL %s: A=%h B=%h cin=%b actual %h expected %h",
               req, opA, opB, carryIn, actual, expected);
    end
  endtask

  function automatic logic [32:0] refAdd(input logic [31:0] x, input logic [31:0] y,
                                         input logic c);
    return {1'b0, x} + {1'b0, y} + {32'd0, c};
  endfunction

  // Drive after the rising edge, sample at the falling edge.
  task automatic runCase(input string req, input logic [31:0] x, input logic [31:0] y,
                         input logic c);
    @(posedge clk);
    opA = x; opB = y; carryIn = c;
    @(negedge clk);
    checkResult(req, {carryOut, sumOut}, refAdd(x, y, c));
  endtask

  // Expect a hand-computed value as well as the reference.
  task automatic runKnown(input string req, input logic [31:0] x, input logic [31:0] y,
                          input logic c, input logic [32:0] known);
    runCase(req, x, y, c);
    checkResult(req, {carryOut, sumOut}, known);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // idle inputs after start: zero sum, no carry (R1, R2)
    checkResult("R1 idle", {carryOut, sumOut}, 33'd0);

    for (int i = 0; i < NUM_VEC; i++)
      runCase("R1/R2 table", VEC_TABLE[i][64:33], VEC_TABLE[i][32:1], VEC_TABLE[i][0]);

    runKnown("R2 all ones plus one", 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, {1'b1, 32'h0});
    runKnown("R3 zero operands cin", 32'h0, 32'h0, 1'b1, 33'd1);
    runKnown("R4 propagate chain", 32'hAAAA_AAAA, 32'h5555_5555, 1'b1, {1'b1, 32'h0});
    runKnown("R4 propagate no cin", 32'hAAAA_AAAA, 32'h5555_5555, 1'b0, {1'b0, 32'hFFFF_FFFF});
    runKnown("R5 all slices generate", 32'h8888_8888, 32'h8888_8888, 1'b0,
             {1'b1, 32'h1111_1110});
    runKnown("R6 distant generate", 32'h0FFF_FFF8, 32'h0000_0008, 1'b0,
             {1'b0, 32'h1000_0000});
    runKnown("R7 boundary via cin", 32'h0000_FFFF, 32'h0, 1'b1, {1'b0, 32'h0001_0000});
    runKnown("R7 boundary via operand", 32'h0000_FFFF, 32'h0000_0001, 1'b0,
             {1'b0, 32'h0001_0000});
    runKnown("R7 no boundary carry", 32'h0000_FFFE, 32'h0000_0001, 1'b0,
             {1'b0, 32'h0000_FFFF});

    // R8: change inputs between edges and sample after a short delay
    @(posedge clk);
    #1;
    opA = 32'h0000_FFFF; opB = 32'hFFFF_0000; carryIn = 1'b1;
    #1;
    checkResult("R8 same step response", {carryOut, sumOut}, {1'b1, 32'h0});
    carryIn = 1'b0;
    #1;
    checkResult("R8 same step response", {carryOut, sumOut}, {1'b0, 32'hFFFF_FFFF});

    for (int i = 0; i < NUM_RAND; i++)
      runCase("R1/R2 random", $urandom, $urandom, 1'($urandom));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule